// File: doc/BRIEF.md
# Page Fill Engine for Local Memory

This block clears a region of a local tightly coupled memory to a fixed byte value. It works in whole 64-byte pages. The host first writes a start address and an end address through a small register port. It then writes the end register again with a launch flag set. From that point the engine runs on its own: it issues one write beat per clock cycle on a plain memory write port and reports its progress through a status register.

Before the fill starts, the engine aligns the range to page boundaries. The start address is rounded down to a page boundary. The end address is rounded up to the next page boundary and is treated as exclusive. Every byte of every covered page receives 0x5A.

The write port can be a full page wide, so that one beat writes one page. It can also be a fraction of a page wide, in which case each page takes several consecutive beats. The `BEAT_BYTES` parameter selects the width. The memory array itself sits outside this block, as does any arbitration with other users of that memory.

Top module: `page_fill_engine`

## Requirements
- R1: After reset, the start, end and status registers all read 0 and `mem_we` is low.
- R2: Register offsets and fields:
  - the start address sits in bits ADDR_BITS-1:0 at offset 0x18;
  - the end address sits in bits ADDR_BITS-1:0 at offset 0x1C, and that register's bit 22 holds the last written launch flag;
  - status at offset 0x20 gives pending in bit 0 and done in bit 1;
  - every other bit, and every other offset, reads 0.
- R3: A write to offset 0x1C with bit 22 at 1, made while pending is 0, sets pending and clears done, visible the cycle after the write. A write with bit 22 at 0 only stores the address.
- R4: The fill covers pages from floor(start/64) up to, but not including, ceil(end/64). Beats are issued in ascending address order, one per cycle, starting the cycle after launch. `mem_addr` is the byte address divided by BEAT_BYTES.
- R5: Every written beat carries 0x5A in each byte.
- R6: One cycle after the last beat, pending clears and done sets. For a range of P pages, done becomes visible P*(64/BEAT_BYTES)+1 cycles after the launch edge.
- R7: If ceil(end/64) is not greater than floor(start/64), no beat is written and done is set one cycle after launch.
- R8: While pending is 1, writes to offsets 0x18 and 0x1C are ignored. This includes a second launch. The fill range and the values read back are unchanged.
- R9: With BEAT_BYTES below 64, each page takes 64/BEAT_BYTES consecutive beats at consecutive beat addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_OFS_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_we | output | 1 | Memory write beat valid |
| mem_addr | output | ADDR_BITS-log2(BEAT_BYTES) | Beat index in the memory |
| mem_wdata | output | 8*BEAT_BYTES | Beat data, the fill byte in every lane |

## Verification
Corruption of the page counter, the beat counter or the latched end page shows up directly on the port:
- a wrong or out-of-range `mem_addr` appears on the very first wrong beat;
- a missing beat or an extra beat appears as a beat count that differs from the arithmetic page count;
- a wrong end condition moves the cycle in which done appears.

A pending flag that fails to clear, or a launch that is not ignored while busy, is caught within one fill. It shows either as a status read that never reaches done, or as a changed register readback. Sweeping start and end addresses across a small address space covers every combination of page-aligned and unaligned bounds, including empty ranges, on both a full-page port and a quarter-page port.

// File: rtl/page_fill_engine.sv
module page_fill_engine #(
  parameter int ADDR_BITS  = 22,
  parameter int BEAT_BYTES = 64,
  parameter logic [7:0] FILL_BYTE = 8'h5A,
  parameter int REG_OFS_W  = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_we,
  input  logic [REG_OFS_W-1:0]                  reg_addr,
  input  logic [31:0]                           reg_wdata,
  output logic [31:0]                           reg_rdata,
  output logic                                  mem_we,
  output logic [ADDR_BITS-$clog2(BEAT_BYTES)-1:0] mem_addr,
  output logic [8*BEAT_BYTES-1:0]               mem_wdata
);
  localparam int PAGE_LG = 6;
  localparam int BEAT_LG = $clog2(BEAT_BYTES);
  localparam int BEATS   = (1 << PAGE_LG) / BEAT_BYTES;
  localparam int BCNT_LG = PAGE_LG - BEAT_LG;
  localparam int PG_W    = ADDR_BITS - PAGE_LG;
  localparam int MEM_AW  = ADDR_BITS - BEAT_LG;
  localparam int VLD     = 22;
  localparam logic [REG_OFS_W-1:0] OFS_START  = REG_OFS_W'('h18);
  localparam logic [REG_OFS_W-1:0] OFS_END    = REG_OFS_W'('h1C);
  localparam logic [REG_OFS_W-1:0] OFS_STATUS = REG_OFS_W'('h20);

  logic [ADDR_BITS-1:0] start_q, end_q;
  logic                 end_vld_q;
  logic                 pending, done;
  logic [PG_W:0]        cur_pg, end_pg;
  logic [ADDR_BITS:0]   end_round;
  logic                 last_beat, have_work;
  logic                 wr_start, wr_end, launch;
  logic                 unused_bits;

  assign wr_start  = reg_we && reg_addr == OFS_START && !pending;
  assign wr_end    = reg_we && reg_addr == OFS_END && !pending;
  assign launch    = wr_end && reg_wdata[VLD];
  assign end_round = {1'b0, reg_wdata[ADDR_BITS-1:0]} + (ADDR_BITS+1)'(63);
  assign have_work = cur_pg < end_pg;
  assign mem_we    = pending && have_work;
  assign mem_wdata = {BEAT_BYTES{FILL_BYTE}};
  assign unused_bits = ^{reg_wdata, end_round[PAGE_LG-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      end_q     <= '0;
      end_vld_q <= 1'b0;
    end else begin
      if (wr_start) start_q <= reg_wdata[ADDR_BITS-1:0];
      if (wr_end) begin
        end_q     <= reg_wdata[ADDR_BITS-1:0];
        end_vld_q <= reg_wdata[VLD];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      done    <= 1'b0;
      cur_pg  <= '0;
      end_pg  <= '0;
    end else if (launch) begin
      pending <= 1'b1;
      done    <= 1'b0;
      cur_pg  <= {1'b0, start_q[ADDR_BITS-1:PAGE_LG]};
      end_pg  <= end_round[ADDR_BITS:PAGE_LG];
    end else if (pending) begin
      if (have_work) begin
        if (last_beat) cur_pg <= cur_pg + (PG_W+1)'(1);
      end else begin
        pending <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  generate
    if (BEATS == 1) begin : g_full
      assign last_beat = 1'b1;
      assign mem_addr  = cur_pg[PG_W-1:0];
    end else begin : g_beats
      logic [BCNT_LG-1:0] beat;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      beat <= '0;
        else if (launch) beat <= '0;
        else if (mem_we) beat <= beat + BCNT_LG'(1);
      end
      assign last_beat = &beat;
      assign mem_addr  = {cur_pg[PG_W-1:0], beat};
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_START:  reg_rdata[ADDR_BITS-1:0] = start_q;
      OFS_END: begin
        reg_rdata[ADDR_BITS-1:0] = end_q;
        reg_rdata[VLD]           = end_vld_q;
      end
      OFS_STATUS: reg_rdata[1:0] = {done, pending};
      default:    reg_rdata = '0;
    endcase
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && done)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we || mem_addr == $past(mem_addr) + MEM_AW'(1))); // R4
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !mem_we) |=> done); // R7
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && $past(pending)) |-> ($stable(start_q) && $stable(end_q))); // R8
  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pending)); // R6
endmodule

// File: tb/tb_page_fill_engine.sv
`timescale 1ns/1ps
module tb_page_fill_engine;
  localparam int AB = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = 6'h20;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdw, rdn;
  logic w_we, n_we;
  logic [3:0] w_addr;
  logic [5:0] n_addr;
  logic [511:0] w_data;
  logic [127:0] n_data;

  int checks = 0, fails = 0;
  int w_base, w_n, w_idx, n_base, n_n, n_idx;

  always #10 clk = ~clk;

  page_fill_engine #(.ADDR_BITS(AB), .BEAT_BYTES(64)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdw), .mem_we(w_we),
    .mem_addr(w_addr), .mem_wdata(w_data));

  page_fill_engine #(.ADDR_BITS(AB), .BEAT_BYTES(16)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdn), .mem_we(n_we),
    .mem_addr(n_addr), .mem_wdata(n_data));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (w_we) begin
      chk(w_idx < w_n, "R4 wide beat count", w_idx, w_n);
      chk(int'(w_addr) == w_base + w_idx, "R4 wide address", w_addr, w_base + w_idx);
      chk(w_data == {64{8'h5A}}, "R5 wide data", w_data[63:0], 64'h5A5A5A5A5A5A5A5A);
      w_idx++;
    end
    if (n_we) begin
      chk(n_idx < n_n, "R9 narrow beat count", n_idx, n_n);
      chk(int'(n_addr) == n_base + n_idx, "R9 narrow address", n_addr, n_base + n_idx);
      chk(n_data == {16{8'h5A}}, "R5 narrow data", n_data[63:0], 64'h5A5A5A5A5A5A5A5A);
      n_idx++;
    end
  end

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 6'h20;
  endtask

  task automatic read_both(input logic [5:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(rdw == exp, tag, rdw, exp);
    chk(rdn == exp, tag, rdn, exp);
    reg_addr = 6'h20;
    #1;
  endtask

  task automatic fill(input int s, input int e, input bit interfere);
    int sp, ep, n, cyc, dw, dn;
    sp = s >> 6;
    ep = (e + 63) >> 6;
    n = (ep > sp) ? ep - sp : 0;
    w_base = sp; w_n = n; w_idx = 0;
    n_base = sp * 4; n_n = n * 4; n_idx = 0;
    reg_write(6'h18, s);
    reg_write(6'h1C, 32'h0040_0000 | e);
    #1;
    chk(rdw[1:0] == 2'b01, "R3 wide pending at launch", rdw[1:0], 1);
    chk(rdn[1:0] == 2'b01, "R3 narrow pending at launch", rdn[1:0], 1);
    cyc = 0; dw = -1; dn = -1;
    if (interfere) begin
      reg_write(6'h18, 32'h0000_0200);
      reg_write(6'h1C, 32'h0040_0040);
      cyc = 2;
    end
    while ((dw < 0 || dn < 0) && cyc < 400) begin
      @(negedge clk);
      cyc++;
      #1;
      if (dw < 0 && rdw[1]) dw = cyc;
      if (dn < 0 && rdn[1]) dn = cyc;
    end
    chk(w_idx == n, (n == 0) ? "R7 wide no beats" : "R4 wide total beats", w_idx, n);
    chk(n_idx == 4 * n, (n == 0) ? "R7 narrow no beats" : "R9 narrow total beats", n_idx, 4 * n);
    if (!interfere) begin
      chk(dw == n + 1, (n == 0) ? "R7 wide done timing" : "R6 wide done timing", dw, n + 1);
      chk(dn == 4 * n + 1, "R6 narrow done timing", dn, 4 * n + 1);
    end
    chk(rdw[1:0] == 2'b10, "R6 wide status", rdw[1:0], 2);
    chk(rdn[1:0] == 2'b10, "R6 narrow status", rdn[1:0], 2);
    if (interfere) begin
      read_both(6'h18, s, "R8 start unchanged");
      read_both(6'h1C, 32'h0040_0000 | e, "R8 end unchanged");
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    w_n = 0; n_n = 0; w_idx = 0; n_idx = 0; w_base = 0; n_base = 0;
    repeat (3) @(negedge clk);
    read_both(6'h18, 0, "R1 start reset");
    read_both(6'h1C, 0, "R1 end reset");
    read_both(6'h20, 0, "R1 status reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!w_we && !n_we, "R1 no write after reset", w_we, 0);
    reg_write(6'h18, 32'hFFFF_FFFF);
    read_both(6'h18, 32'h3FF, "R2 start field width");
    reg_write(6'h1C, 32'h0000_0155);
    read_both(6'h1C, 32'h155, "R2 end readback without flag");
    read_both(6'h20, 0, "R3 no launch without flag");
    read_both(6'h00, 0, "R2 unmapped offset");
    @(negedge clk);
    chk(!w_we && !n_we, "R3 no beats without flag", w_we, 0);
    fill(0, 1023, 1'b1);
    fill(64, 64, 1'b0);
    fill(65, 64, 1'b0);
    fill(63, 0, 1'b0);
    fill(64, 65, 1'b0);
    fill(1023, 1023, 1'b0);
    fill(0, 1023, 1'b0);
    fill(100, 900, 1'b1);
    for (int s = 0; s < 1024; s += 61)
      for (int e = 0; e < 1024; e += 67)
        fill(s, e, 1'b0);
    read_both(6'h1C, 32'h0040_0000 | 32'd1005, "R2 end readback with flag");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule